// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block is the digital core of a hysteretic buck converter. It has no oscillator. Comparators outside the block are digitized into flags, and from those flags the block decides cycle by cycle when to drive the high-side and low-side gate enables. An on-pulse begins only when the output is below its target, the minimum off-time has run out and the valley current limit is clear. The pulse then runs for a fixed number of clock cycles, whatever the comparators do in the meantime.

Gate hand-off uses adaptive dead time. Each switch waits for a flag showing that the other switch has really turned off. At light load the low side turns off at the inductor current zero crossing, so the stage skips pulses. While the output voltage is being moved to a new setting, a transition-mode input disables that zero-cross turn-off. In that mode a negative current-limit trip parks both switches for one on-time. A disable input overrides everything.

Top module: `cot_switch_seq`

## Requirements
- R1: After reset, with the block enabled and no demand, the high-side enable is low and the low-side enable is high.
- R2: An on-pulse is started only when fb_low is high, the minimum off-time has elapsed and ilim_pos is low, all in the same cycle. While ilim_pos is high no pulse starts. Once ilim_pos clears, with the other two conditions true, hs_on rises two cycles later.
- R3: The on-time is sampled when hs_on rises, and hs_on stays high for exactly that many cycles. A change of fb_low or ton_cycles during the pulse does not shorten or lengthen it.
- R4: An on-time value of 0 is treated as 1 cycle.
- R5: Under continuous demand with ideal hand-off flags, hs_on stays low for exactly TOFF_MIN+2 cycles between pulses.
- R6: After a start decision both enables are low. hs_on rises only in the cycle after a cycle in which lgate_low was high. Once a pulse has been decided, it is issued even if fb_low has since dropped.
- R7: After hs_on falls, ls_on stays low until phase_low is seen high, and then rises on the next cycle. hs_on and ls_on are never high together.
- R8: With trans_mode low, zero_cross high during the low-side phase turns ls_on off on the next cycle. ls_on then stays off until the next on-pulse.
- R9: With trans_mode high, zero_cross has no effect and ls_on stays high.
- R10: With trans_mode high, ilim_neg high during the low-side phase turns both enables off for exactly max(ton_cycles,1) cycles. After that the low side returns, or a pulse starts if demand is present. With trans_mode low, ilim_neg is ignored.
- R11: While fb_low stays low, no on-pulse is issued and hs_on stays low.
- R12: run_en low forces hs_on low and ls_on high in the same cycle. After run_en returns, the next pulse under continuous demand rises exactly TOFF_MIN+2 cycles after the last edge with run_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enable. Low forces high side off and low side on |
| fb_low | input | 1 | Feedback is below the reference |
| ilim_pos | input | 1 | Valley (positive) current limit tripped |
| ilim_neg | input | 1 | Negative current limit tripped |
| zero_cross | input | 1 | Inductor current has reached zero |
| phase_low | input | 1 | Phase node is below its low threshold |
| lgate_low | input | 1 | Low-side gate is below its off threshold |
| trans_mode | input | 1 | Output-voltage transition in progress |
| ton_cycles | input | TON_W | On-time in clock cycles |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The bench targets the points where a hysteretic sequencer most often goes wrong, and each case has a visible failure if the design is wrong:
- The pulse width is measured while fb_low drops and ton_cycles changes mid-pulse. A design that does not latch the on-time cuts the pulse short or stretches it.
- The off gap under continuous demand is measured to the cycle. An off-by-one in the minimum off-timer shows up as a gap of the wrong length.
- The lgate_low and phase_low flags are each held low to prove that the switches wait for them. A design without adaptive dead time would switch early and could overlap the gates.
- Zero-cross skipping is run both with and without transition mode, and the length of the negative-current hold-off is counted. Ignoring trans_mode would wrongly skip during a transition, or would fail to park both switches after a negative-limit trip.

// File: rtl/cot_pkg.sv
package cot_pkg;

  typedef enum logic [2:0] {
    ST_LS_ON    = 3'd0,
    ST_WAIT_LGL = 3'd1,
    ST_ON       = 3'd2,
    ST_WAIT_PH  = 3'd3,
    ST_SKIP     = 3'd4,
    ST_NEG_HOLD = 3'd5
  } cot_state_t;

  // effective pulse length: a zero request becomes one cycle
  function automatic int unsigned ton_floor(input int unsigned req);
    return (req == 0) ? 1 : req;
  endfunction

endpackage

// File: rtl/cot_min_off_timer.sv
module cot_min_off_timer #(
  parameter int unsigned TOFF_MIN = 25,
  localparam int unsigned CW = $clog2(TOFF_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (cnt < CW'(TOFF_MIN)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= CW'(TOFF_MIN));
endmodule

// File: rtl/cot_pulse_timer.sv
module cot_pulse_timer #(
  parameter int unsigned TON_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TON_W-1:0] load_val,
  output logic             last
);
  logic [TON_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == TON_W'(1));
endmodule

// File: rtl/cot_fsm.sv
module cot_fsm
  import cot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic fb_low,
  input  logic ilim_pos,
  input  logic ilim_neg,
  input  logic zero_cross,
  input  logic phase_low,
  input  logic lgate_low,
  input  logic trans_mode,
  input  logic off_done,
  input  logic pulse_last,
  output logic load_pulse,
  output logic clr_off,
  output logic ev_start,
  output logic ev_neg_trip,
  output logic hs_on,
  output logic ls_on
);
  cot_state_t st, nxt;
  logic start_ok, start_raw, neg_raw;

  assign start_ok = fb_low && off_done && !ilim_pos;

  always_comb begin
    nxt        = st;
    load_pulse = 1'b0;
    start_raw  = 1'b0;
    neg_raw    = 1'b0;
    unique case (st)
      ST_LS_ON: begin
        if (trans_mode && ilim_neg) begin
          nxt = ST_NEG_HOLD; load_pulse = 1'b1; neg_raw = 1'b1;
        end else if (start_ok) begin
          nxt = ST_WAIT_LGL; start_raw = 1'b1;
        end else if (!trans_mode && zero_cross) begin
          nxt = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (start_ok) begin
          nxt = ST_WAIT_LGL; start_raw = 1'b1;
        end
      end
      ST_WAIT_LGL: begin
        if (lgate_low) begin
          nxt = ST_ON; load_pulse = 1'b1;
        end
      end
      ST_ON: begin
        if (pulse_last) nxt = ST_WAIT_PH;
      end
      ST_WAIT_PH: begin
        if (phase_low) nxt = ST_LS_ON;
      end
      ST_NEG_HOLD: begin
        if (pulse_last) begin
          if (start_ok) begin
            nxt = ST_WAIT_LGL; start_raw = 1'b1;
          end else begin
            nxt = ST_LS_ON;
          end
        end
      end
      default: nxt = ST_LS_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) st <= ST_LS_ON;
    else st <= nxt;
  end

  assign clr_off     = !run_en || (st == ST_ON);
  assign ev_start    = run_en && start_raw;
  assign ev_neg_trip = run_en && neg_raw;
  assign hs_on       = run_en && (st == ST_ON);
  assign ls_on       = !run_en || (st == ST_LS_ON);
endmodule

// File: rtl/cot_switch_seq.sv
module cot_switch_seq
  import cot_pkg::*;
#(
  parameter int unsigned TON_W    = 8,
  parameter int unsigned TOFF_MIN = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fb_low,
  input  logic             ilim_pos,
  input  logic             ilim_neg,
  input  logic             zero_cross,
  input  logic             phase_low,
  input  logic             lgate_low,
  input  logic             trans_mode,
  input  logic [TON_W-1:0] ton_cycles,
  output logic             hs_on,
  output logic             ls_on
);
  logic off_done, pulse_last, load_pulse, clr_off;
  logic ev_start, ev_neg_trip;
  logic [TON_W-1:0] ton_eff;

  assign ton_eff = TON_W'(ton_floor(int'(ton_cycles)));

  cot_min_off_timer #(.TOFF_MIN(TOFF_MIN)) u_off (
    .clk(clk), .rst_n(rst_n), .clr(clr_off), .done(off_done)
  );

  cot_pulse_timer #(.TON_W(TON_W)) u_ton (
    .clk(clk), .rst_n(rst_n), .load(load_pulse), .load_val(ton_eff),
    .last(pulse_last)
  );

  cot_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fb_low(fb_low),
    .ilim_pos(ilim_pos), .ilim_neg(ilim_neg), .zero_cross(zero_cross),
    .phase_low(phase_low), .lgate_low(lgate_low), .trans_mode(trans_mode),
    .off_done(off_done), .pulse_last(pulse_last), .load_pulse(load_pulse),
    .clr_off(clr_off), .ev_start(ev_start), .ev_neg_trip(ev_neg_trip),
    .hs_on(hs_on), .ls_on(ls_on)
  );
endmodule

// File: rtl/cot_switch_seq_chk.sv
module cot_switch_seq_chk
  import cot_pkg::*;
#(
  parameter int unsigned TON_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             fb_low,
  input logic             ilim_neg,
  input logic             zero_cross,
  input logic             lgate_low,
  input logic             trans_mode,
  input logic [TON_W-1:0] ton_cycles,
  input logic             hs_on,
  input logic             ls_on,
  input logic             ev_start,
  input logic             ev_neg_trip
);
  logic             hs_q, clean;
  logic [TON_W-1:0] ton_q;
  logic [TON_W:0]   wcnt, wexp;
  logic             hs_fall;

  assign hs_fall = hs_q && !hs_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0; clean <= 1'b0; ton_q <= '0; wcnt <= '0; wexp <= '0;
    end else begin
      hs_q  <= hs_on;
      ton_q <= ton_cycles;
      if (hs_on && !hs_q) begin
        wcnt  <= (TON_W+1)'(1);
        wexp  <= (TON_W+1)'(ton_floor(int'(ton_q)));
        clean <= run_en;
      end else if (hs_on) begin
        wcnt <= wcnt + 1'b1;
      end
      if (!run_en) clean <= 1'b0;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on)); // R7
  AST_HS_AFTER_LGL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(lgate_low)); // R6
  AST_START_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && run_en |=> !hs_on && (!ls_on || !run_en)); // R6
  AST_HS_FALL_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_on) && run_en |-> !ls_on); // R7
  AST_ON_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall && clean && run_en |-> wcnt == wexp); // R3
  AST_SKIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !trans_mode && zero_cross && ls_on && !fb_low && !ev_neg_trip
      |=> !ls_on || !run_en); // R8
  AST_TRANS_KEEP_LS: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && trans_mode && !ilim_neg && ls_on && !fb_low |=> ls_on); // R9
  AST_NEG_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_neg_trip |=> !hs_on && (!ls_on || !run_en)); // R10
  AST_DISABLE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !hs_on); // R12
endmodule

bind cot_switch_seq cot_switch_seq_chk #(.TON_W(TON_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .fb_low(fb_low),
  .ilim_neg(ilim_neg), .zero_cross(zero_cross), .lgate_low(lgate_low),
  .trans_mode(trans_mode), .ton_cycles(ton_cycles), .hs_on(hs_on),
  .ls_on(ls_on), .ev_start(ev_start), .ev_neg_trip(ev_neg_trip)
);

// File: tb/cot_switch_seq_tb_top.sv
module cot_switch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TON_W      = 8;
  localparam int TOFF       = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b1, fb_low = 1'b0, ilim_pos = 1'b0, ilim_neg = 1'b0;
  logic zero_cross = 1'b0, phase_low = 1'b1, lgate_low = 1'b1, trans_mode = 1'b0;
  logic [TON_W-1:0] ton_cycles = 8'd5;
  logic hs_on, ls_on;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cot_switch_seq #(.TON_W(TON_W), .TOFF_MIN(TOFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fb_low(fb_low),
    .ilim_pos(ilim_pos), .ilim_neg(ilim_neg), .zero_cross(zero_cross),
    .phase_low(phase_low), .lgate_low(lgate_low), .trans_mode(trans_mode),
    .ton_cycles(ton_cycles), .hs_on(hs_on), .ls_on(ls_on)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!hs_on && n < 500) begin tick(); n++; end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (hs_on && w < 500) begin w++; tick(); end
  endtask

  task automatic settle();
    int n;
    fb_low = 1'b0;
    n = 0;
    while (hs_on && n < 500) begin tick(); n++; end
    repeat (TOFF + 5) tick();
  endtask

  task automatic t_reset();
    check("R1 hs after reset", int'(hs_on), 0);
    check("R1 ls after reset", int'(ls_on), 1);
  endtask

  task automatic t_no_demand();
    int h = 0;
    fb_low = 1'b0;
    repeat (60) begin tick(); if (hs_on) h++; end
    check("R11 no pulse with fb high", h, 0);
    check("R11 ls stays on", int'(ls_on), 1);
  endtask

  task automatic t_basic();
    int n, w, g;
    ton_cycles = 8'd5; fb_low = 1'b1;
    wait_rise(n);
    pulse_width(w);
    check("R3 pulse width", w, 5);
    g = 0;
    while (!hs_on && g < 500) begin g++; tick(); end
    check("R5 off gap", g, TOFF + 2);
    pulse_width(w);
    check("R3 second width", w, 5);
    settle();
  endtask

  task automatic t_latch();
    int n, w;
    ton_cycles = 8'd7; fb_low = 1'b1;
    wait_rise(n);
    fb_low = 1'b0; ton_cycles = 8'd2;
    pulse_width(w);
    check("R3 latched width", w, 7);
    settle();
  endtask

  task automatic t_ton_zero();
    int n, w;
    ton_cycles = 8'd0; fb_low = 1'b1;
    wait_rise(n);
    fb_low = 1'b0;
    pulse_width(w);
    check("R4 zero on-time", w, 1);
    settle();
  endtask

  task automatic t_ilim();
    int h = 0, n;
    ton_cycles = 8'd4; ilim_pos = 1'b1; fb_low = 1'b1;
    repeat (50) begin tick(); if (hs_on) h++; end
    check("R2 blocked by ilim_pos", h, 0);
    ilim_pos = 1'b0;
    wait_rise(n);
    check("R2 start after ilim clears", n, 2);
    settle();
  endtask

  task automatic t_lgate();
    int h = 0, n;
    ton_cycles = 8'd4; lgate_low = 1'b0; fb_low = 1'b1;
    repeat (20) begin tick(); if (hs_on) h++; end
    check("R6 hs waits for lgate_low", h, 0);
    check("R6 ls off after start", int'(ls_on), 0);
    fb_low = 1'b0; lgate_low = 1'b1;
    wait_rise(n);
    check("R6 latched start after lgate_low", n, 1);
    settle();
  endtask

  task automatic t_phase();
    int n, w, l = 0;
    ton_cycles = 8'd3; fb_low = 1'b1;
    wait_rise(n);
    fb_low = 1'b0; phase_low = 1'b0;
    pulse_width(w);
    repeat (15) begin if (ls_on) l++; tick(); end
    check("R7 ls waits for phase_low", l, 0);
    phase_low = 1'b1;
    tick();
    check("R7 ls after phase_low", int'(ls_on), 1);
    settle();
  endtask

  task automatic t_skip();
    int l = 0, n, w;
    trans_mode = 1'b0; zero_cross = 1'b1;
    tick();
    check("R8 ls off at zero cross", int'(ls_on), 0);
    zero_cross = 1'b0;
    repeat (30) begin tick(); if (ls_on) l++; end
    check("R8 ls stays off until pulse", l, 0);
    ton_cycles = 8'd3; fb_low = 1'b1;
    wait_rise(n);
    fb_low = 1'b0;
    pulse_width(w);
    tick();
    check("R8 ls back after pulse", int'(ls_on), 1);
    settle();
  endtask

  task automatic t_trans();
    int l = 0;
    trans_mode = 1'b1; zero_cross = 1'b1;
    repeat (30) begin tick(); if (ls_on) l++; end
    check("R9 zero cross ignored in transition", l, 30);
    zero_cross = 1'b0;
  endtask

  task automatic t_neg();
    int c = 0, l = 0;
    trans_mode = 1'b1; ton_cycles = 8'd6; ilim_neg = 1'b1;
    tick();
    ilim_neg = 1'b0;
    while (!ls_on && !hs_on && c < 500) begin c++; tick(); end
    check("R10 negative hold length", c, 6);
    check("R10 ls returns", int'(ls_on), 1);
    trans_mode = 1'b0; ilim_neg = 1'b1;
    repeat (10) begin tick(); if (ls_on) l++; end
    check("R10 ilim_neg ignored outside transition", l, 10);
    ilim_neg = 1'b0;
  endtask

  task automatic t_disable();
    int n;
    ton_cycles = 8'd20; fb_low = 1'b1;
    wait_rise(n);
    repeat (3) tick();
    run_en = 1'b0; #1;
    check("R12 hs forced off", int'(hs_on), 0);
    check("R12 ls forced on", int'(ls_on), 1);
    tick();
    run_en = 1'b1;
    wait_rise(n);
    check("R12 restart delay", n, TOFF + 2);
    settle();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_no_demand();
    t_basic();
    t_latch();
    t_ton_zero();
    t_ilim();
    t_lgate();
    t_phase();
    t_skip();
    t_trans();
    t_neg();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule